// File: doc/BRIEF.md
# Word-Command Serial Flash Master

This block is a serial peripheral master that moves exactly one word for every command software issues over a small 32-bit register bus. Software places the outgoing word in the data register, then writes the command register. The command carries four things: the target chip select, the word length, the transfer kind and the number of words that make up the current frame. The block then clocks the word out on the data line or in from the serial input. While it does so it applies the clock polarity, clock phase and select polarity held for that chip select in the mode register. Completion is reported through a busy flag and a word-done flag in the status register.

Select stays asserted from one command to the next, so a flash command, its address and its data can be sent as a sequence of separate words. Select is released in either of two ways: software issues an explicit release command, or the word counter reaches the frame length given in the command. The serial clock is taken from the functional clock through a 16-bit divider with an enable bit. Clearing the enable bit freezes a transfer in place. The three-pin variant receives on the same bidirectional line that carries outgoing data.

Top module: `wordcmd_spi_master`

## Requirements
- R1: After reset, status reads 0, every select output sits at its inactive level (high, since all polarities reset to 0), sclk is low and dq0_oe is low.
- R2: A command (bus word address 2) with type field bits 18:16 equal to 1, 2, 5 or 6 is accepted when not busy. It sets busy and clears word-done at the accepting edge. The word length is bits 25:19 plus one, capped at 32 bits. After length × P clock cycles, busy clears and word-done sets.
- R3: Type 2 (write) and type 6 (three-pin write) send the low length bits of the data register, most significant first, on dq0_o. dq0_oe is high only while such a write is busy.
- R4: Type 1 reads from dq1_i and type 5 (three-pin read) reads from dq0_i, with dq0_oe low in both. The received bits land right-aligned in the data register, and its upper bits read 0.
- R5: Each bit lasts P = divider+1 functional cycles, where the divider is clock-register bits 15:0 and a divider of 0 gives P = 2. With h = P/2 rounded down, sclk rests at the polarity level (mode bit 0). Phase 0 (mode bit 2 clear) drives the other level in bit cycles h..P-1. Phase 1 drives it in cycles 0..h-1.
- R6: While clock-register bit 31 is 0, an accepted transfer makes no progress. It resumes when the bit is set again.
- R7: Mode byte cs sits at bits 8·cs+7..8·cs of mode register address 1. Its bit 1 is the active level of sel[cs]. Only the chip select in command bits 29:28 is ever active, and it is active from the accepting edge until the frame ends.
- R8: Type 4 releases the select. Types 0, 3 and 7 change neither status nor select.
- R9: A frame length (command bits 11:0) of L releases the select at the end of the L-th word of the frame. A frame starts at a command that finds no select active, or that names a different chip select.
- R10: While busy, writes to the command register and the data register (address 4) are ignored.
- R11: Status (address 3) reads busy in bit 0 and word-done in bit 1. The clock register (address 0) reads back bit 31 and bits 15:0 only. The mode register reads back all 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| sclk | output | 1 | Serial clock |
| sel | output | NCS | Chip selects, per-select active level |
| dq0_o | output | 1 | Outgoing data line value |
| dq0_oe | output | 1 | Drive enable for the data line |
| dq0_i | input | 1 | Data line input (three-pin reads) |
| dq1_i | input | 1 | Separate serial input line |

## Verification
Writes and reads are run under all four polarity/phase combinations, with both even and odd bit periods. The odd periods expose an off-by-one in the clock high/low split that even periods hide. Read data is presented with the wrong line carrying the inverse bit, so a swapped input select for the three-pin mode shows up as a complemented result. Word lengths of 4, 8, 12 and a capped 32 bits separate bit ordering from counter length. The frame-length, release-code, frozen-enable and busy-write patterns tell apart each way the select and the progress of a transfer can be held or released.

// File: rtl/wordcmd_spi_master.sv
module wordcmd_spi_master #(
  parameter int NCS    = 4,
  parameter int DATA_W = 32,
  parameter int DIV_W  = 16,
  parameter int FLEN_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              sclk,
  output logic [NCS-1:0]    sel,
  output logic              dq0_o,
  output logic              dq0_oe,
  input  logic              dq0_i,
  input  logic              dq1_i
);
  localparam int CS_W = (NCS > 1) ? $clog2(NCS) : 1;
  localparam int NB_W = $clog2(DATA_W + 1);
  localparam int IX_W = $clog2(DATA_W);
  localparam int PW   = DIV_W + 1;
  localparam logic [31:0] CLK_MASK = 32'h8000_0000 | ((32'd1 << DIV_W) - 32'd1);
  localparam logic [2:0] A_CLK = 3'd0, A_MODE = 3'd1, A_CMD = 3'd2, A_STAT = 3'd3, A_DATA = 3'd4;

  logic [31:0]       clk_q, dc_q, cmd_q;
  logic [DATA_W-1:0] data_q;
  logic              busy_q, wc_q, rd_q, three_q, frame_q;
  logic [CS_W-1:0]   cs_q;
  logic [NB_W-1:0]   nbits_q, bit_q;
  logic [PW-1:0]     ph_q;
  logic [FLEN_W-1:0] flen_q, wdone_q;

  wire en = clk_q[31];
  wire [PW-1:0] per  = (clk_q[DIV_W-1:0] == '0) ? PW'(2) : PW'(clk_q[DIV_W-1:0]) + PW'(1);
  wire [PW-1:0] half = per >> 1;
  wire [7:0] mode = dc_q[{cs_q, 3'b000} +: 8];
  wire cpol = mode[0];
  wire cpha = mode[2];

  wire we_clk  = reg_we && reg_addr == A_CLK;
  wire we_mode = reg_we && reg_addr == A_MODE;
  wire we_cmd  = reg_we && reg_addr == A_CMD;
  wire we_data = reg_we && reg_addr == A_DATA;
  wire cmd_go  = we_cmd && !busy_q;

  wire [2:0] ctype = reg_wdata[18:16];
  wire [6:0] wl    = reg_wdata[25:19];
  wire start = cmd_go && (ctype == 3'd1 || ctype == 3'd2 || ctype == 3'd5 || ctype == 3'd6);
  wire inval = cmd_go && ctype == 3'd4;
  wire [CS_W-1:0] cs_new = reg_wdata[28 +: CS_W];
  wire [NB_W-1:0] nb_new = (32'(wl) >= DATA_W - 1) ? NB_W'(DATA_W) : NB_W'(wl) + NB_W'(1);

  wire bit_end  = busy_q && en && (ph_q >= per - PW'(1));
  wire last_bit = bit_end && (bit_q == nbits_q - NB_W'(1));
  wire din = three_q ? dq0_i : dq1_i;
  wire [FLEN_W-1:0] wdone_nx = wdone_q + FLEN_W'(1);
  wire [NB_W-1:0] idx = nbits_q - bit_q - NB_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_q <= '0; dc_q <= '0; cmd_q <= '0; data_q <= '0;
      busy_q <= 1'b0; wc_q <= 1'b0; rd_q <= 1'b0; three_q <= 1'b0; frame_q <= 1'b0;
      cs_q <= '0; nbits_q <= '0; bit_q <= '0; ph_q <= '0; flen_q <= '0; wdone_q <= '0;
    end else begin
      if (we_clk)  clk_q <= reg_wdata & CLK_MASK;
      if (we_mode) dc_q <= reg_wdata;
      if (we_data && !busy_q) data_q <= reg_wdata[DATA_W-1:0];
      if (cmd_go)  cmd_q <= reg_wdata;
      if (inval)   frame_q <= 1'b0;
      if (start) begin
        busy_q  <= 1'b1;
        wc_q    <= 1'b0;
        rd_q    <= ctype[0];
        three_q <= ctype[2];
        nbits_q <= nb_new;
        bit_q   <= '0;
        ph_q    <= '0;
        flen_q  <= reg_wdata[FLEN_W-1:0];
        cs_q    <= cs_new;
        frame_q <= 1'b1;
        if (ctype[0]) data_q <= '0;
        if (!frame_q || cs_new != cs_q) wdone_q <= '0;
      end
      if (busy_q && en) begin
        if (bit_end) begin
          ph_q <= '0;
          if (rd_q) data_q <= {data_q[DATA_W-2:0], din};
          if (last_bit) begin
            busy_q  <= 1'b0;
            wc_q    <= 1'b1;
            wdone_q <= wdone_nx;
            if (wdone_nx == flen_q) frame_q <= 1'b0;
          end else begin
            bit_q <= bit_q + NB_W'(1);
          end
        end else begin
          ph_q <= ph_q + PW'(1);
        end
      end
    end
  end

  assign dq0_oe = busy_q && !rd_q;
  assign dq0_o  = dq0_oe && data_q[idx[IX_W-1:0]];
  assign sclk   = cpol ^ (busy_q && (cpha ? (ph_q < half) : (ph_q >= half)));

  for (genvar i = 0; i < NCS; i++) begin : g_sel
    assign sel[i] = (frame_q && cs_q == CS_W'(i)) ? dc_q[8*i+1] : !dc_q[8*i+1];
  end

  always_comb begin
    case (reg_addr)
      A_CLK:   reg_rdata = clk_q;
      A_MODE:  reg_rdata = dc_q;
      A_CMD:   reg_rdata = cmd_q;
      A_STAT:  reg_rdata = {30'd0, wc_q, busy_q};
      A_DATA:  reg_rdata = 32'(data_q);
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/wordcmd_spi_master_chk.sv
module wordcmd_spi_master_chk #(
  parameter int NCS  = 4,
  parameter int NB_W = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy,
  input logic            wc,
  input logic            oe,
  input logic            cmd_we,
  input logic            en,
  input logic [NCS-1:0]  sel,
  input logic [31:0]     dc,
  input logic [31:0]     cmd_q,
  input logic [NB_W-1:0] bitn
);
  logic [NCS-1:0] act;
  always_comb
    for (int i = 0; i < NCS; i++) act[i] = (sel[i] == dc[8*i+1]);

  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(act)); // R7
  AST_BUSY_SELECTS: assert property (@(posedge clk) disable iff (!rst_n) busy |-> act != '0); // R7
  AST_WC_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) busy |-> !wc); // R2
  AST_DONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> wc); // R2
  AST_OE_IN_XFER: assert property (@(posedge clk) disable iff (!rst_n) oe |-> busy); // R3
  AST_BUSY_CMD_DROPPED: assert property (@(posedge clk) disable iff (!rst_n) (busy && cmd_we) |=> $stable(cmd_q)); // R10
  AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) (busy && !en) |=> $stable(bitn)); // R6
endmodule

bind wordcmd_spi_master wordcmd_spi_master_chk #(.NCS(NCS), .NB_W(NB_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy_q), .wc(wc_q), .oe(dq0_oe), .cmd_we(we_cmd),
  .en(en), .sel(sel), .dc(dc_q), .cmd_q(cmd_q), .bitn(bit_q)
);

// File: tb/wordcmd_spi_master_test.sv
`timescale 1ns/1ps
module wordcmd_spi_master_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic sclk, dq0_o, dq0_oe;
  logic dq0_i = 1'b0, dq1_i = 1'b0;
  logic [3:0] sel;
  int tests = 0, fails = 0;

  always #2.5 clk = ~clk;

  wordcmd_spi_master uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .sclk(sclk), .sel(sel), .dq0_o(dq0_o), .dq0_oe(dq0_oe),
    .dq0_i(dq0_i), .dq1_i(dq1_i)
  );

  // behavioural reference state
  logic m_busy, m_wc, m_rd, m_three, m_frame, m_en;
  logic [31:0] m_data, m_dc, slave_word;
  logic [15:0] m_div;
  int m_t, m_n, m_cs, m_len, m_done;
  logic sl_bit;

  function automatic int period();
    return (m_div == 0) ? 2 : int'(m_div) + 1;
  endfunction

  function automatic logic [3:0] exp_sel();
    logic [3:0] e;
    for (int i = 0; i < 4; i++) e[i] = (m_frame && m_cs == i) ? m_dc[8*i+1] : !m_dc[8*i+1];
    return e;
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_wc = 0; m_rd = 0; m_three = 0; m_frame = 0; m_en = 0;
      m_data = 0; m_dc = 0; m_div = 0; m_t = 0; m_n = 1; m_cs = 0; m_len = 0; m_done = 0;
    end else begin
      automatic logic b0 = m_busy;
      automatic int p = period();
      if (m_busy && m_en) begin
        if (m_t % p == p - 1) begin
          if (m_rd) m_data = {m_data[30:0], sl_bit};
          if (m_t / p == m_n - 1) begin
            m_busy = 0; m_wc = 1; m_done++;
            if (m_done == m_len) m_frame = 0;
          end
        end
        m_t++;
      end
      if (reg_we) begin
        case (reg_addr)
          3'd0: begin m_div = reg_wdata[15:0]; m_en = reg_wdata[31]; end
          3'd1: m_dc = reg_wdata;
          3'd4: if (!b0) m_data = reg_wdata;
          3'd2: if (!b0) begin
            automatic int ty = int'(reg_wdata[18:16]);
            automatic int cs = int'(reg_wdata[29:28]);
            if (ty == 1 || ty == 2 || ty == 5 || ty == 6) begin
              if (!m_frame || cs != m_cs) m_done = 0;
              m_cs = cs; m_frame = 1; m_len = int'(reg_wdata[11:0]);
              m_n = (int'(reg_wdata[25:19]) + 1 > 32) ? 32 : int'(reg_wdata[25:19]) + 1;
              m_busy = 1; m_wc = 0; m_t = 0;
              m_rd = (ty == 1 || ty == 5); m_three = (ty >= 5);
              if (m_rd) m_data = 0;
            end else if (ty == 4) m_frame = 0;
          end
          default: ;
        endcase
      end
    end
  end

  // slave: correct bit on the selected input line, inverse on the other
  always @(negedge clk) begin
    automatic int p = period();
    automatic int bt = m_t / p;
    if (rst_n && m_busy && m_rd && bt < m_n) sl_bit = slave_word[m_n-1-bt];
    else sl_bit = 1'b0;
    dq1_i <= m_three ? !sl_bit : sl_bit;
    dq0_i <= m_three ? sl_bit : !sl_bit;
  end

  // per-cycle comparison against the model
  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      automatic int p = period();
      automatic int ph = m_t % p;
      automatic int bt = m_t / p;
      automatic int h = p / 2;
      automatic logic [7:0] md = m_dc[8*m_cs +: 8];
      automatic logic e_sclk = md[0] ^ (m_busy && (md[2] ? (ph < h) : (ph >= h)));
      automatic logic e_oe = m_busy && !m_rd;
      automatic logic e_do = e_oe ? m_data[m_n-1-bt] : 1'b0;
      chk("R5 sclk", 32'(sclk), 32'(e_sclk));
      chk("R7 sel", 32'(sel), 32'(exp_sel()));
      chk("R3 dq0_oe", 32'(dq0_oe), 32'(e_oe));
      chk("R3 dq0_o", 32'(dq0_o), 32'(e_do));
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #0.5; d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 4000; i++) begin
      rd(3'd3, s);
      if (!s[0]) break;
    end
  endtask

  function automatic logic [31:0] cmdw(input int cs, input int wlf, input int ty, input int len);
    return (32'(cs) << 28) | (32'(wlf) << 19) | (32'(ty) << 16) | 32'(len);
  endfunction

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL R2 watchdog expired");
    summary();
  end

  initial begin
    logic [31:0] v;
    slave_word = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(3'd3, v); chk("R1 status", v, 0);
    chk("R1 sel", 32'(sel), 32'hF);
    chk("R1 sclk", 32'(sclk), 0);
    chk("R1 oe", 32'(dq0_oe), 0);

    // write, P=2, mode 0
    wr(3'd0, 32'h8000_0000);
    wr(3'd4, 32'h0000_12A5);
    wr(3'd2, cmdw(0, 7, 2, 12'hFFF));
    wait_idle();
    rd(3'd3, v); chk("R2 status done", v, 2);
    chk("R7 sel held", 32'(sel[0]), 0);
    rd(3'd4, v); chk("R11 data readback", v, 32'h12A5);
    wr(3'd2, cmdw(0, 0, 4, 0));
    chk("R8 release", 32'(sel), 32'hF);

    // modes per select, odd period
    wr(3'd1, 32'h1C02_0500);
    rd(3'd1, v); chk("R11 mode readback", v, 32'h1C02_0500);
    wr(3'd0, 32'h8000_0004);
    slave_word = 32'h3C;
    wr(3'd2, cmdw(1, 7, 1, 12'hFFF));
    wait_idle();
    rd(3'd4, v); chk("R4 read cs1", v, 32'h3C);
    chk("R5 idle polarity", 32'(sclk), 1);
    wr(3'd2, cmdw(1, 0, 4, 0));

    // three-pin read on cs2, active-high select
    slave_word = 32'hABC;
    wr(3'd2, cmdw(2, 11, 5, 12'hFFF));
    chk("R7 active high", 32'(sel[2]), 1);
    chk("R4 three-pin oe", 32'(dq0_oe), 0);
    wait_idle();
    rd(3'd4, v); chk("R4 three-pin read", v, 32'hABC);
    wr(3'd2, cmdw(2, 0, 4, 0));
    chk("R8 release cs2", 32'(sel[2]), 0);

    // length capped at 32
    wr(3'd0, 32'h8000_0001);
    slave_word = 32'hDEAD_BEEF;
    wr(3'd2, cmdw(3, 39, 1, 12'hFFF));
    wait_idle();
    rd(3'd4, v); chk("R2 capped read", v, 32'hDEAD_BEEF);
    wr(3'd2, cmdw(3, 0, 4, 0));

    // enable cleared freezes
    wr(3'd0, 32'h0000_0001);
    wr(3'd4, 32'h3);
    wr(3'd2, cmdw(0, 3, 6, 12'hFFF));
    repeat (20) @(negedge clk);
    rd(3'd3, v); chk("R6 frozen busy", v, 1);
    wr(3'd0, 32'h8000_0001);
    wait_idle();
    rd(3'd3, v); chk("R6 resumed done", v, 2);

    // writes during busy ignored
    wr(3'd4, 32'h81);
    wr(3'd2, cmdw(0, 7, 2, 12'hFFF));
    wr(3'd2, cmdw(3, 7, 1, 12'hFFF));
    wr(3'd4, 32'hFF);
    wait_idle();
    rd(3'd4, v); chk("R10 data kept", v, 32'h81);
    rd(3'd2, v); chk("R10 cmd kept", v, cmdw(0, 7, 2, 12'hFFF));
    chk("R10 select kept", 32'(sel[0]), 0);

    // release and no-op codes
    wr(3'd2, cmdw(0, 0, 4, 0));
    wr(3'd2, cmdw(1, 7, 7, 12'hFFF));
    wr(3'd2, cmdw(1, 7, 3, 12'hFFF));
    wr(3'd2, cmdw(1, 7, 0, 12'hFFF));
    rd(3'd3, v); chk("R8 no-op status", v, 2);
    chk("R8 no-op sel", 32'(sel), 32'hB);

    // frame length 2
    wr(3'd4, 32'h5A);
    wr(3'd2, cmdw(0, 7, 2, 2));
    wait_idle();
    chk("R9 first word held", 32'(sel[0]), 0);
    wr(3'd2, cmdw(0, 7, 2, 2));
    wait_idle();
    chk("R9 auto release", 32'(sel[0]), 1);

    // clock register mask
    wr(3'd0, 32'h7FFF_FFFF);
    rd(3'd0, v); chk("R11 clock mask", v, 32'h0000_FFFF);
    wr(3'd0, 32'h8000_0000);
    rd(3'd0, v); chk("R11 clock readback", v, 32'h8000_0000);
    repeat (4) @(negedge clk);
    summary();
  end
endmodule